// File: doc/BRIEF.md
# Protected Clock Register Bank

This block is the register front end of a real-time clock device. It sits behind a serial slave that has already decoded the bus. That slave hands it single-cycle strobes: transaction start (with a direction flag), address load, write byte, read request and stop. The block holds a 56-byte map at addresses 00h to 37h and one auto-incrementing pointer that is shared by reads and writes.

The eight bytes at 00h to 07h are the live time. The block does not store them. An external time counter supplies them on a flat input bus, and the block freezes a copy of that bus when a read transaction opens. Every read of the time range inside that transaction returns the frozen copy, so a counter tick in the middle of a burst cannot tear the value. Writes to the time range are not stored either. Each accepted write is passed to the counter as a one-cycle load strobe carrying the byte index and the value. Such a write is accepted only while bit 6 of the control byte at 0Ch is set.

The other 48 bytes are ordinary storage and accept writes at any time. Within that storage, 08h–09h hold status, 0Ah–0Bh a counter, 0Ch–14h control, 15h–1Ch daylight-saving settings, 1Dh–28h alarms, and 29h–37h three timestamp groups.

Top module: `rtc_regbank`

## Requirements
- R1: While bit 6 of register 0Ch is 0, a write whose pointer is in 00h–07h has no effect: `tload_o` stays low and the pointer still advances.
- R2: While bit 6 of 0Ch is 1, a write to 00h–07h raises `tload_o` for exactly one cycle, on the edge that takes the write. `tload_idx_o` carries the address (0–7) and `tload_data_o` carries the byte.
- R3: Writes to 08h–37h are stored whatever the value of the protection bit, and they read back unchanged.
- R4: Each write stores at the pointer and then advances it. A burst may therefore start at any address and run across section boundaries, including from the time range into storage.
- R5: An address load sets the pointer. Inside a read transaction, each `rd_i` returns the byte at the pointer on `rdata_o` with `rvalid_o` high in the following cycle, then advances the pointer. A read transaction lasts from a start with `rd_dir_i`=1 until a stop or another start. A `rd_i` outside a read transaction is ignored: `rvalid_o` stays low and the pointer does not move.
- R6: At a start with `rd_dir_i`=1, the whole of `live_time_i` is copied to a snapshot. Byte k of the bus (bits 8k+7:8k) is address k. Reads of 00h–07h return the snapshot, and changes on `live_time_i` after the start are not seen until the next read start.
- R7: After a stop the pointer keeps its value, which is the last accessed address plus one. A later read with no address load continues from there.
- R8: The pointer wraps to 00h after any access at 37h or above. Addresses 38h–FFh read as 00h and ignore writes.
- R9: After reset the pointer is 00h, the protection bit and all stored bytes are 00h, and `rvalid_o` and `tload_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transaction start strobe (including a repeated start) |
| rd_dir_i | input | 1 | Direction qualifying `start_i`: 1 means read |
| stop_i | input | 1 | Transaction stop strobe |
| addr_load_i | input | 1 | Loads `addr_i` into the pointer |
| addr_i | input | 8 | Register address |
| wr_i | input | 1 | Write strobe for `wdata_i` |
| wdata_i | input | 8 | Write byte |
| rd_i | input | 1 | Read request strobe |
| live_time_i | input | 64 | Live time bytes from the counter, byte k at bits 8k+7:8k |
| rdata_o | output | 8 | Read byte |
| rvalid_o | output | 1 | `rdata_o` valid, one cycle after `rd_i` |
| tload_o | output | 1 | One-cycle load strobe to the time counter |
| tload_idx_o | output | 3 | Time byte index for the load |
| tload_data_o | output | 8 | Time byte value for the load |

## Verification
The embedded assertions watch four properties on every cycle:
- a blocked time write never produces a load strobe;
- every load strobe follows an accepted write;
- the pointer wraps after 37h;
- the snapshot holds still for as long as a read transaction is open, and a stray read request produces no data.

Only the bench's scenarios can show the rest: that stored bytes come back intact, that a burst crosses from the time range into storage, that the snapshot returns the old time while the live bus has moved on, and that the next read after a stop resumes at the right address.

// File: rtl/rtc_regbank.sv
module rtc_regbank #(
  parameter int AW     = 8,
  parameter int DW     = 8,
  parameter int CLKB   = 8,
  parameter int LAST   = 'h37,
  parameter int CTRL   = 'h0C,
  parameter int PROT_B = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               rd_dir_i,
  input  logic               stop_i,
  input  logic               addr_load_i,
  input  logic [AW-1:0]      addr_i,
  input  logic               wr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic               rd_i,
  input  logic [CLKB*DW-1:0] live_time_i,
  output logic [DW-1:0]      rdata_o,
  output logic               rvalid_o,
  output logic               tload_o,
  output logic [$clog2(CLKB)-1:0] tload_idx_o,
  output logic [DW-1:0]      tload_data_o
);
  localparam int CW   = $clog2(CLKB);
  localparam int NREG = LAST - CLKB + 1;
  localparam int RW   = $clog2(NREG + CLKB);

  logic [DW-1:0]      regs [NREG];
  logic [CLKB*DW-1:0] snap;
  logic [AW-1:0]      ptr;
  logic               rd_act;

  wire          in_clk  = ptr < AW'(CLKB);
  wire          in_reg  = !in_clk && ptr <= AW'(LAST);
  wire [RW-1:0] ridx    = RW'(ptr) - RW'(CLKB);
  wire          prot    = regs[CTRL-CLKB][PROT_B];
  wire [AW-1:0] ptr_nxt = (ptr >= AW'(LAST)) ? '0 : ptr + 1'b1;
  wire          rd_ok   = rd_i && rd_act;
  wire          rd_open = start_i && rd_dir_i;

  logic [DW-1:0] rd_byte;
  always_comb begin
    rd_byte = '0;
    if (in_clk)      rd_byte = snap[{ptr[CW-1:0], 3'b000} +: DW];
    else if (in_reg) rd_byte = regs[ridx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr          <= '0;
      snap         <= '0;
      rd_act       <= 1'b0;
      rdata_o      <= '0;
      rvalid_o     <= 1'b0;
      tload_o      <= 1'b0;
      tload_idx_o  <= '0;
      tload_data_o <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      tload_o  <= 1'b0;
      rvalid_o <= 1'b0;
      if (start_i) rd_act <= rd_dir_i;
      else if (stop_i) rd_act <= 1'b0;
      if (rd_open) snap <= live_time_i;
      if (addr_load_i) begin
        ptr <= addr_i;
      end else if (wr_i) begin
        if (in_clk && prot) begin
          tload_o      <= 1'b1;
          tload_idx_o  <= ptr[CW-1:0];
          tload_data_o <= wdata_i;
        end else if (in_reg) begin
          regs[ridx] <= wdata_i;
        end
        ptr <= ptr_nxt;
      end else if (rd_ok) begin
        rdata_o  <= rd_byte;
        rvalid_o <= 1'b1;
        ptr      <= ptr_nxt;
      end
    end
  end

  a_r1_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !addr_load_i && in_clk && !prot) |=> !tload_o);

  a_r2_load_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    tload_o |-> ($past(wr_i) && $past(prot)));

  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == AW'(LAST) && !addr_load_i && (wr_i || rd_ok)) |=> ptr == '0);

  a_r6_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && !rd_open) |=> $stable(snap));

  a_r5_stray_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !rd_act && !addr_load_i && !wr_i) |=> (!rvalid_o && $stable(ptr)));
endmodule

// File: tb/rtc_regbank_tb.sv
module rtc_regbank_tb;
  localparam int PERIOD = 10;
  localparam int NV = 8;
  localparam logic [7:0] VADDR [NV] = '{8'h08, 8'h0B, 8'h14, 8'h15, 8'h28, 8'h29, 8'h37, 8'h1D};
  localparam logic [7:0] VDATA [NV] = '{8'hA1, 8'h3C, 8'h7E, 8'h11, 8'hC4, 8'h5A, 8'hF0, 8'h99};

  logic clk = 0, rst_n = 0;
  logic start_i = 0, rd_dir_i = 0, stop_i = 0, addr_load_i = 0, wr_i = 0, rd_i = 0;
  logic [7:0] addr_i = 0, wdata_i = 0;
  logic [63:0] live_time_i = 0;
  logic [7:0] rdata_o, tload_data_o;
  logic rvalid_o, tload_o;
  logic [2:0] tload_idx_o;

  int total = 0, bad = 0;
  logic [7:0] mem [64];

  rtc_regbank u_dut (.clk, .rst_n, .start_i, .rd_dir_i, .stop_i, .addr_load_i, .addr_i,
    .wr_i, .wdata_i, .rd_i, .live_time_i, .rdata_o, .rvalid_o, .tload_o, .tload_idx_o,
    .tload_data_o);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); @(negedge clk); endtask
  task automatic do_start(input bit rd); start_i = 1; rd_dir_i = rd; tick; start_i = 0; rd_dir_i = 0; endtask
  task automatic do_stop; stop_i = 1; tick; stop_i = 0; endtask
  task automatic do_addr(input logic [7:0] a); addr_load_i = 1; addr_i = a; tick; addr_load_i = 0; endtask

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d, input bit exp_ld, input string req);
    wr_i = 1; wdata_i = d; tick; wr_i = 0;
    if (a >= 8'h08 && a <= 8'h37) mem[a] = d;
    chk(tload_o == exp_ld, req, tload_o, exp_ld);
    if (exp_ld) chk(tload_idx_o == a[2:0] && tload_data_o == d, req,
                    {tload_idx_o, tload_data_o}, {a[2:0], d});
  endtask

  task automatic do_rd(input logic [7:0] exp, input string req);
    rd_i = 1; tick; rd_i = 0;
    chk(rvalid_o && rdata_o == exp, req, {rvalid_o, rdata_o}, {1'b1, exp});
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    chk(rvalid_o == 0 && tload_o == 0 && rdata_o == 0, "R9 outputs", {rvalid_o, tload_o, rdata_o}, 0);
    rst_n = 1;
    tick;
    // R9: pointer at 00h, so a current-address read returns the snapshot byte 0
    live_time_i = 64'h0000_0000_0000_00AB;
    do_start(1); do_rd(8'hAB, "R9 pointer"); do_stop;
    do_start(0); do_addr(8'h0C); do_start(1); do_rd(8'h00, "R9 ctrl"); do_stop;

    // R1: protection off
    do_start(0); do_addr(8'h02); do_wr(8'h02, 8'h55, 0, "R1 blocked"); do_stop;

    // R3: table of storage writes and readbacks
    for (int i = 0; i < NV; i++) begin
      do_start(0); do_addr(VADDR[i]); do_wr(VADDR[i], VDATA[i], 0, "R3 write"); do_stop;
    end
    for (int i = 0; i < NV; i++) begin
      do_start(0); do_addr(VADDR[i]); do_start(1); do_rd(VDATA[i], "R3 readback"); do_stop;
    end

    // R4/R5: burst across sections 12h..15h, then sequential read
    do_start(0); do_addr(8'h12);
    for (int i = 0; i < 4; i++) do_wr(8'(8'h12 + i), 8'(8'h21 + i), 0, "R4 burst");
    do_stop;
    do_start(0); do_addr(8'h12); do_start(1);
    for (int i = 0; i < 4; i++) do_rd(8'(8'h21 + i), "R5 sequential");
    do_stop;

    // R2: enable protection, write time bytes
    do_start(0); do_addr(8'h0C); do_wr(8'h0C, 8'h40, 0, "R3 ctrl"); do_stop;
    do_start(0); do_addr(8'h03); do_wr(8'h03, 8'h17, 1, "R2 load");
    tick;
    chk(tload_o == 0, "R2 one cycle", tload_o, 0);
    do_stop;
    do_start(0); do_addr(8'h06);
    do_wr(8'h06, 8'h61, 1, "R4 time burst");
    do_wr(8'h07, 8'h62, 1, "R4 time burst");
    do_wr(8'h08, 8'h88, 0, "R4 cross into storage");
    do_stop;
    do_start(0); do_addr(8'h08); do_start(1); do_rd(8'h88, "R4 crossed byte"); do_stop;

    // R1: protection off again
    do_start(0); do_addr(8'h0C); do_wr(8'h0C, 8'h00, 0, "R3 ctrl"); do_wr(8'h0D, 8'h00, 0, "R3 ctrl");
    do_stop;
    do_start(0); do_addr(8'h05); do_wr(8'h05, 8'h33, 0, "R1 blocked again"); do_stop;

    // R6: snapshot at read start
    live_time_i = 64'h0807_0605_0403_0201;
    do_start(0); do_addr(8'h00); do_start(1);
    live_time_i = 64'hF8F7_F6F5_F4F3_F2F1;
    for (int i = 0; i < 8; i++) do_rd(8'(i + 1), "R6 frozen");
    do_stop;

    // R7: pointer rests at 08h after the stop
    do_start(1); do_rd(mem[8], "R7 continue"); do_rd(mem[9], "R7 continue"); do_stop;

    // R6: next read start refreshes the snapshot
    do_start(0); do_addr(8'h00); do_start(1); do_rd(8'hF1, "R6 refresh"); do_stop;

    // R5: stray read outside a transaction, pointer sits at 01h
    rd_i = 1; tick; rd_i = 0;
    chk(rvalid_o == 0, "R5 stray read", rvalid_o, 0);
    do_start(1); do_rd(8'hF2, "R5 pointer unmoved"); do_stop;

    // R8: wrap and out-of-range
    do_start(0); do_addr(8'h37); do_start(1);
    do_rd(8'hF0, "R8 last"); do_rd(8'hF1, "R8 wrap"); do_stop;
    do_start(0); do_addr(8'h38); do_wr(8'h38, 8'hEE, 0, "R8 write ignored"); do_stop;
    do_start(0); do_addr(8'h38); do_start(1); do_rd(8'h00, "R8 reads zero"); do_stop;
    do_start(0); do_addr(8'h08); do_start(1); do_rd(8'h88, "R8 no alias"); do_stop;
    do_start(0); do_addr(8'hFF); do_start(1); do_rd(8'h00, "R8 high"); do_rd(8'hF1, "R8 wrap high");
    do_stop;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule